// File: doc/BRIEF.md
# Port Pin Crossbar Priority Assigner

This block decides which digital peripheral signal drives each pin of an eight-pin I/O port. Software-visible configuration arrives as plain vectors: one enable bit per peripheral function and one skip bit per pin. The block registers these on a load strobe. From the registered copy it works out combinationally which pin each enabled signal gets. Signals are served in a fixed priority order, and each takes the lowest pin that is still free. The two UART signals always sit on their own fixed pins. The two-wire serial bus (SMBus) clock and data lines are placed together or not at all.

For every pin the block reports a 4-bit select code naming the signal that drives it, or zero for general-purpose I/O. For every signal it reports the pin index it was given and a valid bit. Pins set aside for crystal, voltage reference or convert-start use must be marked in the skip mask. They then stay general-purpose, and the pad logic and the analog mux can use them. An overflow flag shows that some enabled signal found no pin.

Top module: `xbar_assigner`

## Requirements
- R1: On a rising clock edge with `rst_i` high, all enables and skip bits are cleared, so every select code reads 0, no signal is valid and `overflow_o` is 0. On an edge with `rst_i` low and `load_i` high, `en_i` and `skip_i` are captured, and the outputs reflect them from that edge on. When `load_i` is low the stored configuration, and so every output, is held.
- R2: `pin_sel_o[4p+3:4p]` is the code for pin p. 0 is GPIO, and 1 to 13 name the signals in priority order: 1 UART TX, 2 UART RX, 3 SMBus data, 4 SMBus clock, 5 comparator, 6 comparator asynchronous, 7 system clock, 8/9/10 capture/compare channels 0/1/2, 11 counter external clock, 12 timer 0, 13 timer 1. For code c, `sig_valid_o[c-1]` marks it placed and `sig_pin_o[3(c-1)+2:3(c-1)]` holds its pin index. The index reads 0 when the signal is not placed.
- R3: The bits of `en_i` are: bit 0 UART TX, bit 1 UART RX, bit 2 SMBus (both lines), bit 3 comparator, bit 4 comparator asynchronous, bit 5 system clock, bits 6/7/8 channels 0/1/2, bit 9 counter external clock, bit 10 timer 0, bit 11 timer 1.
- R4: An enabled UART TX occupies pin 4 and an enabled UART RX occupies pin 5, whatever else is enabled. Either one may be enabled alone.
- R5: A pin whose skip bit is set always reads code 0 and is never given to any signal. This holds for the UART fixed pins too: a UART signal whose pin is skipped is left unplaced.
- R6: Enabled signals other than the UART signals take the lowest free pin, one after another in priority order. Pins that are skipped or held by a UART signal are passed over, so placed pins rise as priority falls.
- R7: Enabling SMBus places data and clock together on the two lowest free pins, data on the lower one. If fewer than two pins are free, neither line is placed.
- R8: A signal that finds no free pin is left unplaced. Signals further down the order are still tried, so a lower signal can use a single pin that the SMBus pair could not.
- R9: `overflow_o` is 1 exactly when at least one enabled signal is unplaced.
- R10: Pins no signal claims read 0. The number of pins with a nonzero code equals the number of valid signals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, clears the stored configuration |
| load_i | input | 1 | Capture strobe for `en_i` and `skip_i` |
| en_i | input | 12 | Per-function enable bits |
| skip_i | input | 8 | Per-pin skip mask |
| pin_sel_o | output | 32 | Four-bit select code per pin |
| sig_pin_o | output | 39 | Three-bit pin index per signal |
| sig_valid_o | output | 13 | Signal placed flags |
| overflow_o | output | 1 | Some enabled signal found no pin |

## Verification
The outputs follow the registered configuration with no further pipeline. A wrong stored enable or skip bit, or a broken link in the allocation chain, therefore shows on the select codes at the first sample after the load edge. An error in the occupancy chain usually moves every lower-priority signal up or down by one pin. It can also put one signal on two pins, or leave a skipped pin with a nonzero code. Comparing every pin code, every pin index and the flag after each load exposes such a shift at once.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    localparam int NUM_PINS = 8;
    localparam int PIN_W    = $clog2(NUM_PINS);
    localparam int NUM_SIG  = 13;
    localparam int NUM_EN   = 12;
    localparam int SEL_W    = 4;

    localparam int SIG_TX  = 0;
    localparam int SIG_RX  = 1;
    localparam int SIG_SDA = 2;
    localparam int SIG_SCL = 3;

    localparam int EN_TX  = 0;
    localparam int EN_RX  = 1;
    localparam int EN_SMB = 2;

    localparam int TX_PIN = 4;
    localparam int RX_PIN = 5;

    typedef struct packed {
        logic [NUM_EN-1:0]   en;
        logic [NUM_PINS-1:0] skip;
    } xbar_cfg_t;

    typedef struct packed {
        logic             hit;
        logic [PIN_W-1:0] idx;
    } pick_t;

    // lowest clear bit of an occupancy mask
    function automatic pick_t first_free(logic [NUM_PINS-1:0] occ);
        pick_t r;
        r = '0;
        for (int p = NUM_PINS - 1; p >= 0; p--) begin
            if (!occ[p]) begin
                r.hit = 1'b1;
                r.idx = PIN_W'(p);
            end
        end
        return r;
    endfunction

    function automatic logic [NUM_PINS-1:0] pin_bit(logic [PIN_W-1:0] idx);
        return NUM_PINS'(1) << idx;
    endfunction

endpackage

// File: rtl/xbar_cfg_reg.sv
module xbar_cfg_reg
    import xbar_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                load_i,
    input  logic [NUM_EN-1:0]   en_i,
    input  logic [NUM_PINS-1:0] skip_i,
    output xbar_cfg_t           cfg_o
);

    xbar_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load_i) begin
            cfg_d.en   = en_i;
            cfg_d.skip = skip_i;
        end
        if (rst_i) begin
            cfg_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    // R1: without a load strobe the stored configuration holds
    a_r1_hold_without_load: assert property (@(posedge clk_i) disable iff (rst_i)
        !load_i |=> $stable(cfg_q));

endmodule

// File: rtl/xbar_alloc.sv
module xbar_alloc
    import xbar_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  xbar_cfg_t           cfg_i,
    output logic [NUM_SIG-1:0]  req_o,
    output logic [NUM_SIG-1:0]  valid_o,
    output logic [PIN_W-1:0]    pin_o [NUM_SIG]
);

    logic [NUM_PINS-1:0] occ_chain [NUM_SIG+1];
    logic [NUM_SIG-1:0]  req;
    logic [NUM_SIG-1:0]  grant;
    logic [PIN_W-1:0]    pin   [NUM_SIG];
    pick_t               smb_first;
    pick_t               smb_second;

    // request expansion: one SMBus enable feeds both lines
    assign req[SIG_TX]  = cfg_i.en[EN_TX];
    assign req[SIG_RX]  = cfg_i.en[EN_RX];
    assign req[SIG_SDA] = cfg_i.en[EN_SMB];
    assign req[SIG_SCL] = cfg_i.en[EN_SMB];
    generate
        for (genvar k = SIG_SCL + 1; k < NUM_SIG; k++) begin : g_req
            assign req[k] = cfg_i.en[k-1];
        end
    endgenerate

    assign occ_chain[0] = cfg_i.skip;

    generate
        for (genvar i = 0; i < NUM_SIG; i++) begin : g_slot
            if (i == SIG_TX || i == SIG_RX) begin : g_fixed
                localparam int FIX = (i == SIG_TX) ? TX_PIN : RX_PIN;
                assign grant[i] = req[i] && !cfg_i.skip[FIX];
                assign pin[i]   = PIN_W'(FIX);
                assign occ_chain[i+1] = occ_chain[i] |
                                        (grant[i] ? pin_bit(PIN_W'(FIX)) : '0);
            end else if (i == SIG_SDA) begin : g_pair_lo
                assign smb_first  = first_free(occ_chain[i]);
                assign smb_second = first_free(occ_chain[i] | pin_bit(smb_first.idx));
                assign grant[i]   = req[i] && smb_first.hit && smb_second.hit;
                assign pin[i]     = smb_first.idx;
                assign occ_chain[i+1] = occ_chain[i] |
                                        (grant[i] ? pin_bit(smb_first.idx) : '0);
            end else if (i == SIG_SCL) begin : g_pair_hi
                assign grant[i] = grant[SIG_SDA];
                assign pin[i]   = smb_second.idx;
                assign occ_chain[i+1] = occ_chain[i] |
                                        (grant[i] ? pin_bit(smb_second.idx) : '0);
            end else begin : g_greedy
                pick_t pk;
                assign pk       = first_free(occ_chain[i]);
                assign grant[i] = req[i] && pk.hit;
                assign pin[i]   = pk.idx;
                assign occ_chain[i+1] = occ_chain[i] |
                                        (grant[i] ? pin_bit(pk.idx) : '0);

                // R8: a greedy signal is refused only when every pin is taken
                a_r8_refused_only_when_full: assert property (@(posedge clk_i) disable iff (rst_i)
                    (req[i] && !grant[i]) |-> (&occ_chain[i]));
            end
        end
    endgenerate

    generate
        for (genvar i = SIG_SDA; i < NUM_SIG - 1; i++) begin : g_order
            if (i != SIG_SDA) begin : g_chk
                // R6: placed pins rise with falling priority
                a_r6_ascending_pins: assert property (@(posedge clk_i) disable iff (rst_i)
                    (grant[i] && grant[i+1]) |-> (pin[i] < pin[i+1]));
            end
        end
    endgenerate

    // R7: the two SMBus lines are placed together, data below clock
    a_r7_smbus_pair: assert property (@(posedge clk_i) disable iff (rst_i)
        (grant[SIG_SDA] == grant[SIG_SCL]) &&
        (grant[SIG_SDA] -> (pin[SIG_SDA] < pin[SIG_SCL])));

    // R7: pair refused only when fewer than two pins remain
    a_r7_pair_refused_when_short: assert property (@(posedge clk_i) disable iff (rst_i)
        (req[SIG_SDA] && !grant[SIG_SDA]) |-> ($countones(~occ_chain[SIG_SDA]) < 2));

    assign req_o   = req;
    assign valid_o = grant;
    assign pin_o   = pin;

endmodule

// File: rtl/xbar_pin_map.sv
module xbar_pin_map
    import xbar_pkg::*;
(
    input  logic [NUM_SIG-1:0] valid_i,
    input  logic [PIN_W-1:0]   pin_i [NUM_SIG],
    output logic [SEL_W-1:0]   sel_o [NUM_PINS]
);

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            logic [SEL_W-1:0] code;
            always_comb begin
                code = '0;
                for (int s = 0; s < NUM_SIG; s++) begin
                    if (valid_i[s] && (pin_i[s] == PIN_W'(p))) begin
                        code = SEL_W'(s + 1);
                    end
                end
            end
            assign sel_o[p] = code;
        end
    endgenerate

endmodule

// File: rtl/xbar_assigner.sv
module xbar_assigner
    import xbar_pkg::*;
(
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic                        load_i,
    input  logic [NUM_EN-1:0]           en_i,
    input  logic [NUM_PINS-1:0]         skip_i,
    output logic [NUM_PINS*SEL_W-1:0]   pin_sel_o,
    output logic [NUM_SIG*PIN_W-1:0]    sig_pin_o,
    output logic [NUM_SIG-1:0]          sig_valid_o,
    output logic                        overflow_o
);

    xbar_cfg_t          cfg;
    logic [NUM_SIG-1:0] req;
    logic [NUM_SIG-1:0] valid;
    logic [PIN_W-1:0]   pin [NUM_SIG];
    logic [SEL_W-1:0]   sel [NUM_PINS];
    logic [NUM_PINS-1:0] used_pins;

    xbar_cfg_reg u_cfg (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (load_i),
        .en_i   (en_i),
        .skip_i (skip_i),
        .cfg_o  (cfg)
    );

    xbar_alloc u_alloc (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .cfg_i   (cfg),
        .req_o   (req),
        .valid_o (valid),
        .pin_o   (pin)
    );

    xbar_pin_map u_map (
        .valid_i (valid),
        .pin_i   (pin),
        .sel_o   (sel)
    );

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_sel_pack
            assign pin_sel_o[p*SEL_W +: SEL_W] = sel[p];
            assign used_pins[p] = (sel[p] != '0);

            // R5: a skipped pin is never handed out
            a_r5_skip_gpio: assert property (@(posedge clk_i) disable iff (rst_i)
                cfg.skip[p] |-> (sel[p] == '0));
        end
        for (genvar s = 0; s < NUM_SIG; s++) begin : g_pin_pack
            assign sig_pin_o[s*PIN_W +: PIN_W] = valid[s] ? pin[s] : '0;
        end
    endgenerate

    assign sig_valid_o = valid;
    assign overflow_o  = |(req & ~valid);

    // R10: occupied pins match the number of placed signals
    a_r10_pin_count: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(used_pins) == $countones(valid));

    // R4: placed UART lines show on their fixed pins
    a_r4_tx_fixed: assert property (@(posedge clk_i) disable iff (rst_i)
        valid[SIG_TX] |-> (sel[TX_PIN] == SEL_W'(SIG_TX + 1)));
    a_r4_rx_fixed: assert property (@(posedge clk_i) disable iff (rst_i)
        valid[SIG_RX] |-> (sel[RX_PIN] == SEL_W'(SIG_RX + 1)));

    // R9: no overflow means every enabled function got its pins
    a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (rst_i)
        !overflow_o |-> ($countones(valid) == $countones(req)));

endmodule

// File: tb/xbar_assigner_tb.sv
`timescale 1ns/1ps
module xbar_assigner_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [11:0] en = '0;
    logic [7:0]  skip = '0;
    logic [31:0] pin_sel;
    logic [38:0] sig_pin;
    logic [12:0] sig_valid;
    logic        ovf;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [31:0] sel;
        logic [38:0] pins;
        logic [12:0] valid;
        logic        ovf;
        string       tag;
    } exp_t;

    exp_t sb_q [$];

    always #10 clk = ~clk;

    xbar_assigner u_dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .load_i      (load),
        .en_i        (en),
        .skip_i      (skip),
        .pin_sel_o   (pin_sel),
        .sig_pin_o   (sig_pin),
        .sig_valid_o (sig_valid),
        .overflow_o  (ovf)
    );

    // reference built from the requirements: walk pins one by one
    function automatic exp_t model(logic [11:0] e, logic [7:0] sk, string tag);
        exp_t   r;
        logic [7:0] taken;
        bit     rq [13];
        int     at [13];
        int     a;
        int     b;
        taken = sk;
        rq[0] = e[0];
        rq[1] = e[1];
        rq[2] = e[2];
        rq[3] = e[2];
        for (int k = 4; k < 13; k++) rq[k] = e[k-1];
        for (int k = 0; k < 13; k++) at[k] = -1;
        if (rq[0] && !sk[4]) begin at[0] = 4; taken[4] = 1'b1; end
        if (rq[1] && !sk[5]) begin at[1] = 5; taken[5] = 1'b1; end
        if (rq[2]) begin
            a = -1;
            b = -1;
            for (int p = 0; p < 8; p++) begin
                if (!taken[p]) begin
                    if (a < 0) a = p;
                    else if (b < 0) b = p;
                end
            end
            if (b >= 0) begin
                at[2] = a; at[3] = b;
                taken[a] = 1'b1; taken[b] = 1'b1;
            end
        end
        for (int k = 4; k < 13; k++) begin
            if (rq[k]) begin
                for (int p = 0; p < 8; p++) begin
                    if (!taken[p] && at[k] < 0) begin
                        at[k] = p;
                        taken[p] = 1'b1;
                    end
                end
            end
        end
        r.sel = '0;
        r.pins = '0;
        r.valid = '0;
        r.ovf = 1'b0;
        r.tag = tag;
        for (int k = 0; k < 13; k++) begin
            if (at[k] >= 0) begin
                r.valid[k] = 1'b1;
                r.pins[k*3 +: 3] = 3'(at[k]);
                r.sel[at[k]*4 +: 4] = 4'(k + 1);
            end else if (rq[k]) begin
                r.ovf = 1'b1;
            end
        end
        return r;
    endfunction

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // driver: load one configuration and queue its expected result
    task automatic apply(logic [11:0] e, logic [7:0] sk, string tag);
        @(negedge clk);
        en = e;
        skip = sk;
        load = 1'b1;
        @(posedge clk);
        #1;
        load = 1'b0;
        sb_q.push_back(model(e, sk, tag));
    endtask

    // monitor: compare at the falling edge after each queued item
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t x;
            x = sb_q.pop_front();
            check(x.tag, "pin_sel",  64'(pin_sel),   64'(x.sel));
            check(x.tag, "sig_pin",  64'(sig_pin),   64'(x.pins));
            check(x.tag, "valid",    64'(sig_valid), 64'(x.valid));
            check(x.tag, "overflow", 64'(ovf),       64'(x.ovf));
        end
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        en = 12'hFFF;
        skip = 8'h00;
        load = 1'b1;
        @(posedge clk);
        #1;
        sb_q.push_back(model(12'h000, 8'h00, "R1"));
        rst = 1'b0;
        load = 1'b0;
        @(negedge clk);

        // R4: TX alone on pin 4, code 1 (R2)
        apply(12'h001, 8'h00, "R4");
        // R4: RX alone on pin 5
        apply(12'h002, 8'h00, "R4");
        // R6 R8 R9: everything enabled, lower ones run out of pins
        apply(12'hFFF, 8'h00, "R6");
        // R5 R7: SMBus pair and comparator above a skipped pin 0
        apply(12'h00C, 8'h01, "R7");
        // R8: single free pin, pair refused, timer 0 takes it
        apply(12'h404, 8'hFD, "R8");
        // R5 R9: TX pin skipped, TX unplaced and overflow set
        apply(12'h009, 8'h10, "R5");
        // R10: three pins used, five stay GPIO
        apply(12'h038, 8'h00, "R10");
        // R3: enable bit positions, channel 1 and counter clock with RX
        apply(12'h282, 8'h0F, "R3");
        // R6: UART pins passed over by greedy signals
        apply(12'hFC3, 8'h05, "R6");
        // R9: exact fit, no overflow
        apply(12'h0F8, 8'hE0, "R9");

        // R1: load low holds the stored configuration
        @(negedge clk);
        en = 12'h555;
        skip = 8'hAA;
        @(posedge clk);
        #1;
        sb_q.push_back(model(12'h0F8, 8'hE0, "R1"));
        @(negedge clk);

        // R1: reset with load high still clears
        @(negedge clk);
        rst = 1'b1;
        load = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        load = 1'b0;
        sb_q.push_back(model(12'h000, 8'h00, "R1"));
        @(negedge clk);

        // R2: last-priority codes on a lightly skipped port
        apply(12'hE00, 8'h81, "R2");
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule